// File: doc/BRIEF.md
# Chained Double-Buffered DMA Channel

This block is one DMA channel that moves 32-bit words in one direction between memory and a device. It keeps two address windows. The active window runs from a running pointer up to an end address. The queued window holds the next start and end pair. When the active window reaches its end and chaining is armed, the queued pair moves into the active registers in the same clock edge. Requests go on with no idle cycle, and a completion flag raises the interrupt so software can refill the queued window and arm chaining again.

Software drives the channel through a register port. Word index 0 is a command/status register, and the other indices hold the window registers and their saved copies. Writes to index 0 are commands. Each command bit either sets or clears one state bit, so a zero write does nothing. The memory side is a plain request/acknowledge port: the address is stable while the request is high, and each acknowledge retires one word.

Top module: `dma_chain_chan`

## Requirements
- R1: Register indices 1..8 hold active pointer, active end, queued start, queued end, saved pointer, saved end, saved start and saved end-of-queue. Each is 32 bits and reads back the value last written unless the engine has updated it.
- R2: Status (index 0) reads ENABLE in bit 0, COMPLETE in bit 1, ARMED in bit 2 and READ in bit 3. After reset, and after a command with the HALT bit (bit 7), ENABLE, COMPLETE and ARMED read 0. HALT overrides every other bit in the same write.
- R3: A command write of zero leaves the status and the window registers unchanged.
- R4: While ENABLE is set and the active pointer differs from the active end, mem_req is high and mem_addr equals the pointer. Each acknowledged beat advances the pointer by 4.
- R5: When the active window ends with ARMED set, the queued start and end load into the active pointer and end on that edge. ARMED clears, COMPLETE sets, ENABLE stays set, and requests continue in the next cycle.
- R6: When the active window ends with ARMED clear, COMPLETE sets and ENABLE clears. The active end register keeps the end address.
- R7: On a chained promotion, the saved end register (index 6) takes the address the finished window reached.
- R8: On this transmit channel, bit 31 of an end address is a flag. It is left out of the end comparison and out of mem_addr. mem_eop is high during the last beat of a window whose end address has that flag set.
- R9: irq equals COMPLETE. Command bit 2 clears COMPLETE, but a completion in the same cycle leaves it set.
- R10: Command bit 3 sets READ and command bit 4 clears it (bit 3 wins if both are set). mem_write is the inverse of READ. Command bit 0 sets ENABLE and bit 1 sets ARMED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Memory beat request |
| mem_addr | output | 32 | Word address of the beat |
| mem_write | output | 1 | 1 when the beat writes memory |
| mem_ack | input | 1 | Beat accepted |
| mem_eop | output | 1 | Last beat of a flagged window |
| irq | output | 1 | Completion interrupt |

## Verification
A reference model is compared with the outputs every cycle while the acknowledge pattern varies. With acknowledge held high, the test checks that the chained promotion leaves no gap between windows. With acknowledge alternating, it checks that the pointer does not advance on a cycle that has no acknowledge. Other cases check details the main run cannot: an empty window, a chained pair whose second end address carries the flag bit, a clear command that lands in the same cycle as a completion, and a halt combined with start bits.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

    typedef enum logic [3:0] {
        RG_CTL      = 4'd0,
        RG_PTR      = 4'd1,
        RG_END      = 4'd2,
        RG_QSTART   = 4'd3,
        RG_QEND     = 4'd4,
        RG_SV_PTR   = 4'd5,
        RG_SV_END   = 4'd6,
        RG_SV_QST   = 4'd7,
        RG_SV_QEND  = 4'd8
    } reg_idx_e;

    localparam int CMD_GO    = 0;
    localparam int CMD_ARM   = 1;
    localparam int CMD_ACK   = 2;
    localparam int CMD_RDDIR = 3;
    localparam int CMD_WRDIR = 4;
    localparam int CMD_HALT  = 7;

    typedef struct packed {
        logic rd_dir;
        logic armed;
        logic complete;
        logic enable;
    } chan_stat_t;

    typedef struct packed {
        logic        beat;
        logic        fin;
        logic [31:0] ptr_inc;
    } eng_evt_t;

    function automatic logic addr_match(input logic [31:0] a, input logic [31:0] b,
                                        input logic tx);
        if (tx) return a[30:0] == b[30:0];
        return a == b;
    endfunction

endpackage

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
    import dma_chain_pkg::*;
#(
    parameter int  ADDR_W = 32,
    parameter int  WORD_W = 32,
    parameter bit  TX_CHANNEL = 1'b1
) (
    input  logic              enable,
    input  logic [ADDR_W-1:0] ptr_q,
    input  logic [ADDR_W-1:0] end_q,
    input  logic              mem_ack,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_eop,
    output eng_evt_t          evt
);
    localparam int STEP     = WORD_W / 8;
    localparam int FLAG_BIT = ADDR_W - 1;

    logic              at_end;
    logic              inc_at_end;
    logic [ADDR_W-1:0] ptr_inc;

    assign ptr_inc    = ptr_q + ADDR_W'(STEP);
    assign at_end     = addr_match(ptr_q, end_q, TX_CHANNEL);
    assign inc_at_end = addr_match(ptr_inc, end_q, TX_CHANNEL);

    assign mem_req     = enable && !at_end;
    assign evt.beat    = mem_req && mem_ack;
    assign evt.fin     = enable && (at_end || (mem_req && mem_ack && inc_at_end));
    assign evt.ptr_inc = ptr_inc;

    generate
        if (TX_CHANNEL) begin : g_tx
            assign mem_addr = {1'b0, ptr_q[FLAG_BIT-1:0]};
            assign mem_eop  = end_q[FLAG_BIT] && mem_req && inc_at_end;
        end else begin : g_rx
            assign mem_addr = ptr_q;
            assign mem_eop  = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/dma_chain_regs.sv
module dma_chain_regs
    import dma_chain_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  eng_evt_t          evt,
    output logic [ADDR_W-1:0] ptr_q,
    output logic [ADDR_W-1:0] end_q,
    output chan_stat_t        stat
);
    localparam int STEP = WORD_W / 8;

    logic [ADDR_W-1:0] qstart_q, qend_q, sv_ptr_q, sv_end_q, sv_qst_q, sv_qend_q;
    logic              ctl_wr;

    assign ctl_wr = reg_wr && (reg_addr == RG_CTL);

    always_ff @(posedge clk) begin
        if (rst) begin
            stat      <= '0;
            ptr_q     <= '0;
            end_q     <= '0;
            qstart_q  <= '0;
            qend_q    <= '0;
            sv_ptr_q  <= '0;
            sv_end_q  <= '0;
            sv_qst_q  <= '0;
            sv_qend_q <= '0;
        end else begin
            if (evt.beat) ptr_q <= evt.ptr_inc;
            if (evt.fin) begin
                stat.complete <= 1'b1;
                if (stat.armed) begin
                    sv_end_q   <= evt.beat ? evt.ptr_inc : ptr_q;
                    ptr_q      <= qstart_q;
                    end_q      <= qend_q;
                    stat.armed <= 1'b0;
                end else begin
                    stat.enable <= 1'b0;
                end
            end
            if (reg_wr) begin
                case (reg_addr)
                    RG_CTL: begin
                        if (reg_wdata[CMD_HALT]) begin
                            stat.enable   <= 1'b0;
                            stat.complete <= 1'b0;
                            stat.armed    <= 1'b0;
                        end else begin
                            if (reg_wdata[CMD_ACK])   stat.complete <= evt.fin;
                            if (reg_wdata[CMD_GO])    stat.enable   <= 1'b1;
                            if (reg_wdata[CMD_ARM])   stat.armed    <= 1'b1;
                            if (reg_wdata[CMD_RDDIR]) stat.rd_dir   <= 1'b1;
                            else if (reg_wdata[CMD_WRDIR]) stat.rd_dir <= 1'b0;
                        end
                    end
                    RG_PTR:     ptr_q     <= reg_wdata;
                    RG_END:     end_q     <= reg_wdata;
                    RG_QSTART:  qstart_q  <= reg_wdata;
                    RG_QEND:    qend_q    <= reg_wdata;
                    RG_SV_PTR:  sv_ptr_q  <= reg_wdata;
                    RG_SV_END:  sv_end_q  <= reg_wdata;
                    RG_SV_QST:  sv_qst_q  <= reg_wdata;
                    RG_SV_QEND: sv_qend_q <= reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (reg_addr)
            RG_CTL:     reg_rdata = {28'b0, stat};
            RG_PTR:     reg_rdata = ptr_q;
            RG_END:     reg_rdata = end_q;
            RG_QSTART:  reg_rdata = qstart_q;
            RG_QEND:    reg_rdata = qend_q;
            RG_SV_PTR:  reg_rdata = sv_ptr_q;
            RG_SV_END:  reg_rdata = sv_end_q;
            RG_SV_QST:  reg_rdata = sv_qst_q;
            RG_SV_QEND: reg_rdata = sv_qend_q;
            default:    reg_rdata = '0;
        endcase
    end

    AST_HALT_QUIETS: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && reg_wdata[CMD_HALT]) |=> (!stat.enable && !stat.complete && !stat.armed)); // R2

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (evt.beat && !evt.fin && !reg_wr) |=> (ptr_q == $past(ptr_q) + ADDR_W'(STEP))); // R4

    AST_CHAIN_STAYS_ON: assert property (@(posedge clk) disable iff (rst)
        (evt.fin && stat.armed && !reg_wr) |=> (stat.enable && stat.complete && !stat.armed)); // R5

    AST_LAST_STOPS: assert property (@(posedge clk) disable iff (rst)
        (evt.fin && !stat.armed && !reg_wr) |=> (!stat.enable && stat.complete)); // R6

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && reg_wdata[CMD_ACK] && !reg_wdata[CMD_HALT] && !evt.fin) |=> !stat.complete); // R9

endmodule

// File: rtl/dma_chain_chan.sv
module dma_chain_chan
    import dma_chain_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter bit TX_CHANNEL = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_write,
    input  logic              mem_ack,
    output logic              mem_eop,
    output logic              irq
);
    eng_evt_t          evt;
    chan_stat_t        stat;
    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] end_q;

    dma_chain_regs #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt(evt),
        .ptr_q(ptr_q), .end_q(end_q), .stat(stat)
    );

    dma_chain_engine #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .TX_CHANNEL(TX_CHANNEL)) u_eng (
        .enable(stat.enable), .ptr_q(ptr_q), .end_q(end_q), .mem_ack(mem_ack),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_eop(mem_eop), .evt(evt)
    );

    assign mem_write = !stat.rd_dir;
    assign irq       = stat.complete;

endmodule

// File: tb/sim_dma_chain_chan.sv
`timescale 1ns/1ps
module sim_dma_chain_chan;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_write, mem_ack, mem_eop, irq;
    logic [31:0] mem_addr;

    int checks = 0;
    int errors = 0;
    int ack_mode = 0;     // 0 always, 1 alternate
    bit running = 0;
    bit done = 0;

    // reference model state
    logic [31:0] m_ptr, m_end, m_qs, m_qe;
    bit m_en, m_cmp, m_arm, m_rd;

    always #2.5 clk = ~clk;

    dma_chain_chan u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_write(mem_write), .mem_ack(mem_ack),
        .mem_eop(mem_eop), .irq(irq)
    );

    function automatic bit same(input logic [31:0] a, input logic [31:0] b);
        return a[30:0] == b[30:0];
    endfunction

    initial mem_ack = 1'b1;
    always @(negedge clk) begin
        if (ack_mode == 1) mem_ack <= ~mem_ack;
        else mem_ack <= 1'b1;
    end

    always @(posedge clk) begin
        bit req, beat, fin;
        logic [31:0] nxt;
        if (rst) begin
            m_ptr = 0; m_end = 0; m_qs = 0; m_qe = 0;
            m_en = 0; m_cmp = 0; m_arm = 0; m_rd = 0;
        end else begin
            req  = m_en && !same(m_ptr, m_end);
            beat = req && mem_ack;
            nxt  = m_ptr + 4;
            fin  = m_en && (!req || (beat && same(nxt, m_end)));
            if (beat) m_ptr = nxt;
            if (fin) begin
                if (m_arm) begin
                    m_ptr = m_qs; m_end = m_qe; m_arm = 0;
                end else m_en = 0;
            end
            if (reg_wr && reg_addr == 0) begin
                if (reg_wdata[7]) begin
                    m_en = 0; m_arm = 0; fin = 0;
                    m_cmp = 0;
                end else begin
                    if (reg_wdata[2]) m_cmp = 0;
                    if (reg_wdata[0]) m_en = 1;
                    if (reg_wdata[1]) m_arm = 1;
                    if (reg_wdata[3]) m_rd = 1;
                    else if (reg_wdata[4]) m_rd = 0;
                end
            end
            if (fin) m_cmp = 1;
            if (reg_wr) begin
                case (reg_addr)
                    1: m_ptr = reg_wdata;
                    2: m_end = reg_wdata;
                    3: m_qs  = reg_wdata;
                    4: m_qe  = reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        bit req;
        if (running && !rst) begin
            req = m_en && !same(m_ptr, m_end);
            chk("R9 irq", {31'b0, irq}, {31'b0, m_cmp});
            chk("R4 mem_req", {31'b0, mem_req}, {31'b0, req});
            if (req) chk("R4/R8 mem_addr", mem_addr, {1'b0, m_ptr[30:0]});
            chk("R10 mem_write", {31'b0, mem_write}, {31'b0, !m_rd});
            chk("R8 mem_eop", {31'b0, mem_eop},
                {31'b0, req && m_end[31] && same(m_ptr + 4, m_end)});
        end
    end

    // callers are aligned just after a negedge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #0.5;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic summary;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        running = 1;
        rd(0, 32'h0, "R2 reset status");
        chk("R9 reset irq", {31'b0, irq}, 32'h0);

        // R1 readback
        wr(5, 32'h1111_0005); wr(6, 32'h2222_0006);
        wr(7, 32'h3333_0007); wr(8, 32'h4444_0008);
        wr(1, 32'h0000_0100); wr(2, 32'h0000_0110);
        wr(3, 32'h0000_0200); wr(4, 32'h8000_0208);
        rd(5, 32'h1111_0005, "R1 saved ptr");
        rd(7, 32'h3333_0007, "R1 saved start");
        rd(8, 32'h4444_0008, "R1 saved qend");
        rd(6, 32'h2222_0006, "R1 saved end");
        rd(1, 32'h0000_0100, "R1 ptr");
        rd(4, 32'h8000_0208, "R1 qend");
        @(negedge clk);

        // chained run, read direction, ack always (R5 R7 R8 R10)
        wr(0, 32'h0000_000B);
        repeat (20) @(negedge clk);
        rd(6, 32'h0000_0110, "R7 saved end after promotion");
        rd(1, 32'h0000_0208, "R6 ptr after last window");
        rd(2, 32'h8000_0208, "R6 end keeps address");
        rd(0, 32'h0000_000A, "R6 status complete, stopped, read");
        @(negedge clk);
        wr(0, 32'h0);
        rd(0, 32'h0000_000A, "R3 zero command");
        rd(1, 32'h0000_0208, "R3 ptr unchanged");
        @(negedge clk);
        wr(0, 32'h0000_0004);
        rd(0, 32'h0000_0008, "R9 ack clears complete");
        chk("R9 irq low", {31'b0, irq}, 32'h0);
        @(negedge clk);

        // alternating ack, write direction
        ack_mode = 1;
        wr(1, 32'h0000_0300); wr(2, 32'h0000_0310);
        wr(0, 32'h0000_0011);
        repeat (20) @(negedge clk);
        rd(1, 32'h0000_0310, "R4 ptr after alternating acks");
        rd(0, 32'h0000_0002, "R10 write dir, complete");
        @(negedge clk);
        ack_mode = 0;

        // clear in the same cycle as a completion
        wr(0, 32'h0000_0004);
        wr(1, 32'h0000_0400); wr(2, 32'h0000_0404);
        wr(0, 32'h0000_0001);
        wr(0, 32'h0000_0004);
        rd(0, 32'h0000_0002, "R9 completion beats same-cycle clear");
        chk("R9 irq stays", {31'b0, irq}, 32'h1);
        @(negedge clk);

        // empty window
        wr(0, 32'h0000_0004);
        wr(1, 32'h0000_0500); wr(2, 32'h0000_0500);
        wr(0, 32'h0000_0001);
        @(negedge clk);
        rd(0, 32'h0000_0002, "R6 empty window completes");
        @(negedge clk);

        // halt wins over go/arm
        wr(1, 32'h0000_0600); wr(2, 32'h0000_0640);
        wr(0, 32'h0000_0083);
        rd(0, 32'h0000_0000, "R2 halt priority");
        @(negedge clk);
        wr(0, 32'h0000_0003);
        repeat (3) @(negedge clk);
        wr(0, 32'h0000_0080);
        rd(0, 32'h0000_0000, "R2 halt mid-transfer");
        @(negedge clk);
        summary();
    end
endmodule